// File: doc/BRIEF.md
# Trap Entry Sequencer

This block applies every architectural state change a small RISC core makes when it enters a trap. The pipeline presents a one-cycle `trapValid` strobe and one or more event lines: hardware exception, memory-management exception, external interrupt, software break or hardware break. Alongside the strobe it presents the current program counter, the machine status word, the exception status word, the saved branch-target register, the delay-slot and immediate-prefix flags, and the pending branch target. One clock later the block presents the new program counter, the updated status, exception-status and branch-target words, and the cleared or kept pipeline flags. It also provides a single register-file write port (enable, index, data) that carries the return address.

The return address depends on the trap kind. For a memory-management exception it is moved back so that an interrupted branch, or an instruction with an immediate prefix, runs again. Each trap kind has its own vector and its own return register. When several events arrive together, one is chosen by a fixed priority. Events that may not be taken in the current state are dropped without any effect.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset, `takeValid` and `rfWe` are 0, and `newPc`, `newMsr`, `newEsr`, `newBtr`, `rfIdx` and `rfData` are all 0.
- R2: A hardware exception writes `curPc`+4 to register 17, sets status bit 9 (exception in progress) and sets `newPc` to 0x20.
- R3: A memory-management exception writes a return address to register 17, sets status bit 9 and sets `newPc` to 0x20. The return address is `curPc`−8 when in a delay slot with `branchImm`=1, `curPc`−4 when in a delay slot with `branchImm`=0, `curPc`−4 when not in a delay slot with `immPrefix`=1, and `curPc` otherwise.
- R4: For both exception kinds, bit 12 of the exception status word is cleared. If `inDelaySlot`=1, bit 12 is then set and `newBtr` takes `branchTarget`; otherwise `newBtr` keeps `curBtr`. The other exception-status bits pass through unchanged.
- R5: On every trap taken, status bit 13 (virtual mode) is copied to bit 14 and bit 11 (user mode) is copied to bit 12, and bits 13 and 11 are then cleared.
- R6: An interrupt writes `curPc` to register 14, clears status bit 1 (interrupt enable) and sets `newPc` to 0x10. The exception status word is left unchanged.
- R7: An interrupt is dropped (no `takeValid`, no output change) when status bit 1 is 0, when status bit 9 or bit 3 is 1, or when `inDelaySlot`=1.
- R8: A hardware break writes `curPc` to register 16, sets status bit 3 (break in progress) and sets `newPc` to 0x18.
- R9: A software break sets status bit 3 and sets `newPc` to `branchTarget`, with no register write.
- R10: After either exception kind, `newDelaySlot` and `newImmPrefix` are 0.
- R11: A hardware exception is dropped while `excSupport`=0. Arbitration then continues with the remaining events.
- R12: When several events are asserted, the priority order is hardware exception, memory-management exception, hardware break, software break, interrupt.
- R13: All outputs update on the first clock edge after `trapValid` and hold otherwise. `takeValid` and `rfWe` are high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapValid | input | 1 | One-cycle strobe qualifying the event lines |
| evHwExc | input | 1 | Hardware exception event |
| evMmuExc | input | 1 | Memory-management exception event |
| evIrq | input | 1 | External interrupt event |
| evSwBrk | input | 1 | Software break event |
| evHwBrk | input | 1 | Hardware break event |
| excSupport | input | 1 | Core configured with exception support |
| curPc | input | 32 | Program counter of the trapped instruction |
| curMsr | input | 32 | Current machine status word |
| curEsr | input | 32 | Current exception status word |
| curBtr | input | 32 | Current saved branch-target register |
| inDelaySlot | input | 1 | Trapped instruction sits in a branch delay slot |
| immPrefix | input | 1 | Trapped instruction carries an immediate prefix |
| branchImm | input | 1 | The branch owning the delay slot had an immediate prefix |
| branchTarget | input | 32 | Pending branch target |
| takeValid | output | 1 | A trap was taken; outputs below are fresh |
| newPc | output | 32 | Next program counter |
| newMsr | output | 32 | Updated machine status word |
| newEsr | output | 32 | Updated exception status word |
| newBtr | output | 32 | Updated saved branch-target register |
| newDelaySlot | output | 1 | Delay-slot flag after entry |
| newImmPrefix | output | 1 | Immediate-prefix flag after entry |
| rfWe | output | 1 | Return-address register write enable |
| rfIdx | output | 5 | Return-address register index |
| rfData | output | 32 | Return-address value |

## Verification
The memory-management return address is driven through all four delay-slot and prefix combinations. A design that adjusts the address wrongly would store an address 4 or 8 bytes off, and the core would then skip or repeat a branch. Each condition that blocks an interrupt is applied on its own, and the outputs are checked to stay frozen. An exception taken in a delay slot is checked for bit 12 and for capture of the branch target. Combined events are driven, including a dropped hardware exception together with a lower-priority event, to confirm that the winner is the correct one and that the dropped event does not block it.

// File: rtl/trap_pkg.sv
package trap_pkg;

  localparam int XLEN = 32;
  localparam int REG_IDX_W = 5;

  // status word bit positions; each saved copy sits one bit above its live bit
  localparam int MSR_IE  = 1;
  localparam int MSR_BIP = 3;
  localparam int MSR_EIP = 9;
  localparam int MSR_UM  = 11;
  localparam int MSR_UMS = MSR_UM + 1;
  localparam int MSR_VM  = 13;
  localparam int MSR_VMS = MSR_VM + 1;

  localparam int ESR_DS  = 12;

  typedef enum logic [2:0] {
    KIND_NONE  = 3'd0,
    KIND_HWEXC = 3'd1,
    KIND_MMU   = 3'd2,
    KIND_HWBRK = 3'd3,
    KIND_SWBRK = 3'd4,
    KIND_IRQ   = 3'd5
  } trapKind_e;

  typedef struct packed {
    logic      fire;
    trapKind_e kind;
  } trapStrobe_t;

endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
(
  input  logic        trapValid,
  input  logic        evHwExc,
  input  logic        evMmuExc,
  input  logic        evIrq,
  input  logic        evSwBrk,
  input  logic        evHwBrk,
  input  logic        excSupport,
  input  logic        msrIe,
  input  logic        msrEip,
  input  logic        msrBip,
  input  logic        inDelaySlot,
  output trapStrobe_t strobe
);

  logic hwExcOk;
  logic irqOk;

  always_comb begin
    hwExcOk = evHwExc && excSupport;
    irqOk   = evIrq && msrIe && !msrEip && !msrBip && !inDelaySlot;
  end

  always_comb begin
    strobe.kind = KIND_NONE;
    if (hwExcOk)       strobe.kind = KIND_HWEXC;
    else if (evMmuExc) strobe.kind = KIND_MMU;
    else if (evHwBrk)  strobe.kind = KIND_HWBRK;
    else if (evSwBrk)  strobe.kind = KIND_SWBRK;
    else if (irqOk)    strobe.kind = KIND_IRQ;
    strobe.fire = trapValid && (strobe.kind != KIND_NONE);
  end

endmodule

// File: rtl/trap_dp.sv
module trap_dp
  import trap_pkg::*;
#(
  parameter int W = XLEN,
  parameter int IW = REG_IDX_W,
  parameter logic [W-1:0] VEC_EXC = 'h20,
  parameter logic [W-1:0] VEC_IRQ = 'h10,
  parameter logic [W-1:0] VEC_BRK = 'h18,
  parameter int REG_EXC = 17,
  parameter int REG_IRQ = 14,
  parameter int REG_BRK = 16,
  parameter int INSN_BYTES = 4
)(
  input  logic          clk,
  input  logic          rstN,
  input  trapStrobe_t   strobe,
  input  logic [W-1:0]  curPc,
  input  logic [W-1:0]  curMsr,
  input  logic [W-1:0]  curEsr,
  input  logic [W-1:0]  curBtr,
  input  logic          inDelaySlot,
  input  logic          immPrefix,
  input  logic          branchImm,
  input  logic [W-1:0]  branchTarget,
  output logic          takeValid,
  output logic [W-1:0]  newPc,
  output logic [W-1:0]  newMsr,
  output logic [W-1:0]  newEsr,
  output logic [W-1:0]  newBtr,
  output logic          newDelaySlot,
  output logic          newImmPrefix,
  output logic          rfWe,
  output logic [IW-1:0] rfIdx,
  output logic [W-1:0]  rfData
);

  localparam logic [W-1:0] STEP = W'(INSN_BYTES);

  logic [W-1:0]  mmuBack;
  logic [W-1:0]  msrSaved;
  logic [W-1:0]  escEsr;
  logic [W-1:0]  nxPc, nxMsr, nxEsr, nxBtr, nxData;
  logic          nxDs, nxImm, nxWe;
  logic [IW-1:0] nxIdx;

  // rewind distance for a memory-management exception
  always_comb begin
    if (inDelaySlot)    mmuBack = branchImm ? (STEP << 1) : STEP;
    else if (immPrefix) mmuBack = STEP;
    else                mmuBack = '0;
  end

  // mode bits shifted into their saved copies, live copies cleared
  always_comb begin
    msrSaved = curMsr;
    msrSaved[MSR_VMS] = curMsr[MSR_VM];
    msrSaved[MSR_UMS] = curMsr[MSR_UM];
    msrSaved[MSR_VM]  = 1'b0;
    msrSaved[MSR_UM]  = 1'b0;
  end

  always_comb begin
    escEsr = curEsr;
    escEsr[ESR_DS] = inDelaySlot;
  end

  always_comb begin
    nxPc   = newPc;
    nxMsr  = msrSaved;
    nxEsr  = curEsr;
    nxBtr  = curBtr;
    nxDs   = inDelaySlot;
    nxImm  = immPrefix;
    nxWe   = 1'b0;
    nxIdx  = rfIdx;
    nxData = rfData;
    unique case (strobe.kind)
      KIND_HWEXC, KIND_MMU: begin
        nxPc   = VEC_EXC;
        nxMsr[MSR_EIP] = 1'b1;
        nxEsr  = escEsr;
        nxBtr  = inDelaySlot ? branchTarget : curBtr;
        nxDs   = 1'b0;
        nxImm  = 1'b0;
        nxWe   = 1'b1;
        nxIdx  = IW'(REG_EXC);
        nxData = (strobe.kind == KIND_HWEXC) ? curPc + STEP : curPc - mmuBack;
      end
      KIND_IRQ: begin
        nxPc   = VEC_IRQ;
        nxMsr[MSR_IE] = 1'b0;
        nxWe   = 1'b1;
        nxIdx  = IW'(REG_IRQ);
        nxData = curPc;
      end
      KIND_HWBRK: begin
        nxPc   = VEC_BRK;
        nxMsr[MSR_BIP] = 1'b1;
        nxWe   = 1'b1;
        nxIdx  = IW'(REG_BRK);
        nxData = curPc;
      end
      KIND_SWBRK: begin
        nxPc   = branchTarget;
        nxMsr[MSR_BIP] = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      takeValid    <= 1'b0;
      rfWe         <= 1'b0;
      newPc        <= '0;
      newMsr       <= '0;
      newEsr       <= '0;
      newBtr       <= '0;
      newDelaySlot <= 1'b0;
      newImmPrefix <= 1'b0;
      rfIdx        <= '0;
      rfData       <= '0;
    end else begin
      takeValid <= strobe.fire;
      rfWe      <= strobe.fire && nxWe;
      if (strobe.fire) begin
        newPc        <= nxPc;
        newMsr       <= nxMsr;
        newEsr       <= nxEsr;
        newBtr       <= nxBtr;
        newDelaySlot <= nxDs;
        newImmPrefix <= nxImm;
        rfIdx        <= nxIdx;
        rfData       <= nxData;
      end
    end
  end

endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_pkg::*;
#(
  parameter int W = XLEN,
  parameter int IW = REG_IDX_W,
  parameter logic [W-1:0] VEC_EXC = 'h20,
  parameter logic [W-1:0] VEC_IRQ = 'h10,
  parameter logic [W-1:0] VEC_BRK = 'h18,
  parameter int REG_EXC = 17,
  parameter int REG_IRQ = 14,
  parameter int REG_BRK = 16
)(
  input  logic          clk,
  input  logic          rstN,
  input  logic          trapValid,
  input  logic          evHwExc,
  input  logic          evMmuExc,
  input  logic          evIrq,
  input  logic          evSwBrk,
  input  logic          evHwBrk,
  input  logic          excSupport,
  input  logic [W-1:0]  curPc,
  input  logic [W-1:0]  curMsr,
  input  logic [W-1:0]  curEsr,
  input  logic [W-1:0]  curBtr,
  input  logic          inDelaySlot,
  input  logic          immPrefix,
  input  logic          branchImm,
  input  logic [W-1:0]  branchTarget,
  output logic          takeValid,
  output logic [W-1:0]  newPc,
  output logic [W-1:0]  newMsr,
  output logic [W-1:0]  newEsr,
  output logic [W-1:0]  newBtr,
  output logic          newDelaySlot,
  output logic          newImmPrefix,
  output logic          rfWe,
  output logic [IW-1:0] rfIdx,
  output logic [W-1:0]  rfData
);

  trapStrobe_t strobe;

  trap_ctrl ctrl_i (
    .trapValid   (trapValid),
    .evHwExc     (evHwExc),
    .evMmuExc    (evMmuExc),
    .evIrq       (evIrq),
    .evSwBrk     (evSwBrk),
    .evHwBrk     (evHwBrk),
    .excSupport  (excSupport),
    .msrIe       (curMsr[MSR_IE]),
    .msrEip      (curMsr[MSR_EIP]),
    .msrBip      (curMsr[MSR_BIP]),
    .inDelaySlot (inDelaySlot),
    .strobe      (strobe)
  );

  trap_dp #(
    .W(W), .IW(IW),
    .VEC_EXC(VEC_EXC), .VEC_IRQ(VEC_IRQ), .VEC_BRK(VEC_BRK),
    .REG_EXC(REG_EXC), .REG_IRQ(REG_IRQ), .REG_BRK(REG_BRK)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .curPc        (curPc),
    .curMsr       (curMsr),
    .curEsr       (curEsr),
    .curBtr       (curBtr),
    .inDelaySlot  (inDelaySlot),
    .immPrefix    (immPrefix),
    .branchImm    (branchImm),
    .branchTarget (branchTarget),
    .takeValid    (takeValid),
    .newPc        (newPc),
    .newMsr       (newMsr),
    .newEsr       (newEsr),
    .newBtr       (newBtr),
    .newDelaySlot (newDelaySlot),
    .newImmPrefix (newImmPrefix),
    .rfWe         (rfWe),
    .rfIdx        (rfIdx),
    .rfData       (rfData)
  );

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
  import trap_pkg::*;
#(
  parameter int W = XLEN,
  parameter int IW = REG_IDX_W,
  parameter logic [W-1:0] VEC_EXC = 'h20,
  parameter logic [W-1:0] VEC_IRQ = 'h10,
  parameter logic [W-1:0] VEC_BRK = 'h18,
  parameter int REG_EXC = 17,
  parameter int REG_IRQ = 14,
  parameter int REG_BRK = 16
)(
  input logic          clk,
  input logic          rstN,
  input logic          trapValid,
  input logic          evHwExc,
  input logic          evMmuExc,
  input logic          evIrq,
  input logic          evSwBrk,
  input logic          evHwBrk,
  input logic [W-1:0]  curMsr,
  input logic          takeValid,
  input logic [W-1:0]  newPc,
  input logic [W-1:0]  newMsr,
  input logic          rfWe,
  input logic [IW-1:0] rfIdx
);

  assert_no_spurious_take_R13: assert property (@(posedge clk) disable iff (!rstN)
    !trapValid |=> !takeValid);

  assert_write_with_take_R13: assert property (@(posedge clk) disable iff (!rstN)
    rfWe |-> takeValid);

  assert_modes_cleared_R5: assert property (@(posedge clk) disable iff (!rstN)
    takeValid |-> (!newMsr[MSR_VM] && !newMsr[MSR_UM]));

  assert_exc_entry_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rfWe && rfIdx == IW'(REG_EXC)) |-> (newMsr[MSR_EIP] && newPc == VEC_EXC));

  assert_irq_entry_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rfWe && rfIdx == IW'(REG_IRQ)) |-> (!newMsr[MSR_IE] && newPc == VEC_IRQ));

  assert_hwbrk_entry_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rfWe && rfIdx == IW'(REG_BRK)) |-> (newMsr[MSR_BIP] && newPc == VEC_BRK));

  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && evIrq && !evHwExc && !evMmuExc && !evSwBrk && !evHwBrk
     && !curMsr[MSR_IE]) |=> !takeValid);

endmodule

bind trap_entry_seq trap_entry_chk #(
  .W(W), .IW(IW),
  .VEC_EXC(VEC_EXC), .VEC_IRQ(VEC_IRQ), .VEC_BRK(VEC_BRK),
  .REG_EXC(REG_EXC), .REG_IRQ(REG_IRQ), .REG_BRK(REG_BRK)
) chk_i (
  .clk(clk), .rstN(rstN), .trapValid(trapValid),
  .evHwExc(evHwExc), .evMmuExc(evMmuExc), .evIrq(evIrq),
  .evSwBrk(evSwBrk), .evHwBrk(evHwBrk), .curMsr(curMsr),
  .takeValid(takeValid), .newPc(newPc), .newMsr(newMsr),
  .rfWe(rfWe), .rfIdx(rfIdx)
);

// File: tb/trap_entry_seq_tb_top.sv
module trap_entry_seq_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trapValid = 1'b0;
  logic evHwExc = 1'b0, evMmuExc = 1'b0, evIrq = 1'b0, evSwBrk = 1'b0, evHwBrk = 1'b0;
  logic excSupport = 1'b1;
  logic [31:0] curPc = '0, curMsr = '0, curEsr = '0, curBtr = '0, branchTarget = '0;
  logic inDelaySlot = 1'b0, immPrefix = 1'b0, branchImm = 1'b0;
  logic takeValid, newDelaySlot, newImmPrefix, rfWe;
  logic [31:0] newPc, newMsr, newEsr, newBtr, rfData;
  logic [4:0] rfIdx;

  int nRun = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  trap_entry_seq dut_i (
    .clk(clk), .rstN(rstN), .trapValid(trapValid),
    .evHwExc(evHwExc), .evMmuExc(evMmuExc), .evIrq(evIrq),
    .evSwBrk(evSwBrk), .evHwBrk(evHwBrk), .excSupport(excSupport),
    .curPc(curPc), .curMsr(curMsr), .curEsr(curEsr), .curBtr(curBtr),
    .inDelaySlot(inDelaySlot), .immPrefix(immPrefix), .branchImm(branchImm),
    .branchTarget(branchTarget), .takeValid(takeValid), .newPc(newPc),
    .newMsr(newMsr), .newEsr(newEsr), .newBtr(newBtr),
    .newDelaySlot(newDelaySlot), .newImmPrefix(newImmPrefix),
    .rfWe(rfWe), .rfIdx(rfIdx), .rfData(rfData)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // events as {hwExc, mmu, hwBrk, swBrk, irq}; outputs sampled one negedge later
  task automatic fire(input logic [4:0] ev);
    @(negedge clk);
    {evHwExc, evMmuExc, evHwBrk, evSwBrk, evIrq} = ev;
    trapValid = 1'b1;
    @(negedge clk);
    trapValid = 1'b0;
    {evHwExc, evMmuExc, evHwBrk, evSwBrk, evIrq} = '0;
  endtask

  task automatic setCtx(input logic [31:0] pc, input logic [31:0] msr, input logic ds,
                        input logic imm, input logic bimm);
    curPc = pc; curMsr = msr; inDelaySlot = ds; immPrefix = imm; branchImm = bimm;
    curEsr = 32'h0000_1005; curBtr = 32'h0000_AAAA; branchTarget = 32'h0000_5000;
  endtask

  task automatic checkFrozen(input string req, input logic [31:0] pc0, input logic [31:0] msr0);
    chk(req, {31'd0, takeValid}, 32'd0);
    chk(req, {31'd0, rfWe}, 32'd0);
    chk(req, newPc, pc0);
    chk(req, newMsr, msr0);
  endtask

  task automatic testReset();
    chk("R1", {30'd0, takeValid, rfWe}, 32'd0);
    chk("R1", newPc, 0); chk("R1", newMsr, 0); chk("R1", newEsr, 0);
    chk("R1", newBtr, 0); chk("R1", {27'd0, rfIdx}, 0); chk("R1", rfData, 0);
  endtask

  task automatic testHwExc();
    setCtx(32'h1000, 32'h0000_2802, 1'b0, 1'b1, 1'b0);
    fire(5'b10000);
    chk("R2", {31'd0, takeValid}, 1);
    chk("R2", {31'd0, rfWe}, 1);
    chk("R2", {27'd0, rfIdx}, 17);
    chk("R2", rfData, 32'h1004);
    chk("R2", newPc, 32'h20);
    chk("R5", newMsr, 32'h0000_5202);
    chk("R4", newEsr, 32'h0000_0005);
    chk("R4", newBtr, 32'h0000_AAAA);
    chk("R10", {30'd0, newDelaySlot, newImmPrefix}, 0);
    @(negedge clk);
    chk("R13", {30'd0, takeValid, rfWe}, 0);
    chk("R13", newPc, 32'h20);
    setCtx(32'h2000, 32'h0, 1'b1, 1'b0, 1'b0);
    curEsr = 32'h0;
    fire(5'b10000);
    chk("R4", newEsr, 32'h0000_1000);
    chk("R4", newBtr, 32'h0000_5000);
    chk("R2", rfData, 32'h2004);
    chk("R10", {30'd0, newDelaySlot, newImmPrefix}, 0);
  endtask

  task automatic testMmu();
    setCtx(32'h3000, 32'h0000_2000, 1'b0, 1'b0, 1'b0);
    fire(5'b01000);
    chk("R3", rfData, 32'h3000); chk("R3", newPc, 32'h20);
    chk("R3", {27'd0, rfIdx}, 17);
    chk("R5", newMsr, 32'h0000_4200);
    setCtx(32'h3000, 32'h0, 1'b1, 1'b0, 1'b0);
    fire(5'b01000);
    chk("R3", rfData, 32'h2FFC);
    chk("R4", newEsr, 32'h0000_1005);
    chk("R4", newBtr, 32'h0000_5000);
    setCtx(32'h3000, 32'h0, 1'b1, 1'b1, 1'b1);
    fire(5'b01000);
    chk("R3", rfData, 32'h2FF8);
    chk("R10", {30'd0, newDelaySlot, newImmPrefix}, 0);
    setCtx(32'h3000, 32'h0, 1'b0, 1'b1, 1'b0);
    fire(5'b01000);
    chk("R3", rfData, 32'h2FFC);
    chk("R4", newEsr, 32'h0000_0005);
  endtask

  task automatic testIrq();
    setCtx(32'h4000, 32'h0000_2802, 1'b0, 1'b0, 1'b0);
    fire(5'b00001);
    chk("R6", {31'd0, rfWe}, 1);
    chk("R6", {27'd0, rfIdx}, 14);
    chk("R6", rfData, 32'h4000);
    chk("R6", newPc, 32'h10);
    chk("R6", newMsr, 32'h0000_5000);
    chk("R6", newEsr, 32'h0000_1005);
  endtask

  task automatic testIrqBlocked();
    logic [31:0] pc0, msr0;
    pc0 = newPc; msr0 = newMsr;
    setCtx(32'h4100, 32'h0, 1'b0, 1'b0, 1'b0);
    fire(5'b00001); checkFrozen("R7 ie", pc0, msr0);
    setCtx(32'h4100, 32'h0000_0202, 1'b0, 1'b0, 1'b0);
    fire(5'b00001); checkFrozen("R7 eip", pc0, msr0);
    setCtx(32'h4100, 32'h0000_000A, 1'b0, 1'b0, 1'b0);
    fire(5'b00001); checkFrozen("R7 bip", pc0, msr0);
    setCtx(32'h4100, 32'h0000_0002, 1'b1, 1'b0, 1'b0);
    fire(5'b00001); checkFrozen("R7 ds", pc0, msr0);
  endtask

  task automatic testBreaks();
    setCtx(32'h6000, 32'h0000_0800, 1'b0, 1'b0, 1'b0);
    fire(5'b00100);
    chk("R8", {27'd0, rfIdx}, 16);
    chk("R8", rfData, 32'h6000);
    chk("R8", newPc, 32'h18);
    chk("R8", newMsr, 32'h0000_1008);
    setCtx(32'h6100, 32'h0000_2000, 1'b0, 1'b0, 1'b0);
    fire(5'b00010);
    chk("R9", {31'd0, takeValid}, 1);
    chk("R9", {31'd0, rfWe}, 0);
    chk("R9", newPc, 32'h5000);
    chk("R9", newMsr, 32'h0000_4008);
  endtask

  task automatic testNoExcSupport();
    logic [31:0] pc0, msr0;
    pc0 = newPc; msr0 = newMsr;
    excSupport = 1'b0;
    setCtx(32'h7000, 32'h0000_0002, 1'b0, 1'b0, 1'b0);
    fire(5'b10000); checkFrozen("R11", pc0, msr0);
    fire(5'b11000);
    chk("R11", {27'd0, rfIdx}, 17);
    chk("R11", rfData, 32'h7000);
    excSupport = 1'b1;
  endtask

  task automatic testPriority();
    setCtx(32'h8000, 32'h0000_0002, 1'b0, 1'b0, 1'b0);
    fire(5'b10001);
    chk("R12 hwexc>irq", rfData, 32'h8004);
    fire(5'b01100);
    chk("R12 mmu>hwbrk", {27'd0, rfIdx}, 17);
    chk("R12 mmu>hwbrk", rfData, 32'h8000);
    fire(5'b00110);
    chk("R12 hwbrk>swbrk", newPc, 32'h18);
    fire(5'b00011);
    chk("R12 swbrk>irq", newPc, 32'h5000);
    chk("R12 swbrk>irq", {31'd0, rfWe}, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        testReset();
        testHwExc();
        testMmu();
        testIrq();
        testIrqBlocked();
        testBreaks();
        testNoExcSupport();
        testPriority();
      end
      begin
        repeat (5000) @(negedge clk);
        nRun++; nFail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule